// File: doc/BRIEF.md
# Sticky Fault Status Register

This block keeps a 64-bit record of asynchronous faults reported by neighbouring error-detection logic. Each of the nineteen fault sources raises a one-cycle pulse together with a two-bit class tag saying whether the fault was corrected by hardware, is correctable by software, or is uncorrectable. Every accepted pulse sets that source's sticky bit. A class-aware repeat detector raises a multiple-fault flag. The current privilege level is captured with each accepted fault. Two of the sources are bus-data ECC checks. For these, a transaction tracker keeps only the first ECC fault of a 64-byte transfer, together with faults in the same 16-byte subunit, and drops the rest.

Software sees the whole register on a single output. It clears bits by writing ones through a write port, and reading has no side effect. Two syndrome fields come from a separate capture block and appear read-only in the register. The block requests a disrupting trap while interrupts are enabled and a trap-class fault bit is set. It drives an external error pin while a protocol or internal fault is recorded.

Top module: `stk_fault_status`

## Requirements
- R1: After reset every status bit (fault bits 51..33, bit 52, bit 53) reads 0, `trap_req_o` is 0 and `err_pin_o` is 0.
- R2: An accepted pulse on `evt_vld[i]` sets status bit 33+i on the next clock edge. The bit stays set through idle cycles and reads until it is cleared.
- R3: When `wr_en` is high, every bit set in `wr_data` clears the matching bit among bits 53..33, and bits written as 0 keep their value. Bits 19..16 always mirror `msyn_in` and bits 8..0 always mirror `esyn_in`, whatever is written.
- R4: If a fault pulse and a write-one clear reach the same fault bit in the same cycle, the bit ends up set.
- R5: The multiple-fault flag (bit 53) sets when an accepted pulse of class 1 (software-correctable) or 2 (uncorrectable) arrives on a source whose bit is already set.
- R6: A repeated class-0 (hardware-corrected) pulse on a set bit does not set bit 53, and a pulse on a different, clear source does not set it either.
- R7: Sources 0 and 1 (bits 33, 34) are bus ECC sources. A `txn_start` pulse marks the first beat of a new transaction. After an ECC fault is accepted in subunit `sub_idx` = s, ECC pulses with any other subunit value are dropped until the next `txn_start`. A dropped pulse sets no bit and does not touch bit 53.
- R8: On any accepted pulse, bit 52 takes the value of `priv_in` in that cycle. Otherwise a write-one clears it.
- R9: `trap_req_o` is high exactly when `irq_en` is high and at least one fault bit among 51..33 is set. Clearing the last such bit drops it.
- R10: `err_pin_o` is high exactly while bit 51 (source 18) or bit 50 (source 17) is set.
- R11: Bits 63..54, 32..20 and 15..9 always read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| evt_vld | input | 19 | One-cycle fault pulses, source i maps to bit 33+i |
| evt_cls | input | 38 | Class of each source, 2 bits per source (0 hw-corrected, 1 sw-correctable, 2 uncorrectable) |
| priv_in | input | 1 | Privilege state sampled with each accepted fault |
| txn_start | input | 1 | First beat of a new 64-byte bus transaction |
| sub_idx | input | 2 | 16-byte subunit position of the current ECC beat |
| irq_en | input | 1 | Interrupt enable gating the trap request |
| wr_en | input | 1 | Write strobe for write-one-to-clear |
| wr_data | input | 64 | Clear mask |
| msyn_in | input | 4 | Tag syndrome from the capture block |
| esyn_in | input | 9 | Data syndrome from the capture block |
| status_o | output | 64 | Register value |
| trap_req_o | output | 1 | Disrupting trap request |
| err_pin_o | output | 1 | External error pin |

## Verification
On every cycle, the checker confirms several properties. A set fault bit never falls without a matching write-one. A direct (non-ECC) pulse always lands. The multiple-fault flag never rises without a class-1 or class-2 pulse. The trap request is silent while interrupts are disabled. The error pin only follows protocol or internal faults, and reserved bits stay zero. Some behaviours need a specific history and so only the bench's scenarios can show them. These are the class-dependent repeat rule, subunit filtering across a transaction boundary, privilege capture, set-over-clear collisions and the read-only syndrome fields.

// File: rtl/stk_fault_pkg.sv
package stk_fault_pkg;

   localparam int CLS_W = 2;

   typedef enum logic [CLS_W-1:0] {
      CLS_HWC = 2'd0,
      CLS_SWC = 2'd1,
      CLS_UNC = 2'd2,
      CLS_RSV = 2'd3
   } fault_cls_e;

   // Classes whose repeat on a set bit counts as a multiple fault.
   function automatic logic cls_counts_repeat(input logic [CLS_W-1:0] c);
      return (c == CLS_SWC) || (c == CLS_UNC);
   endfunction

endpackage

// File: rtl/stk_ecc_gate.sv
module stk_ecc_gate #(
   parameter int           N_ERR    = 19,
   parameter int           SUB_W    = 2,
   parameter logic [N_ERR-1:0] ECC_MASK = '0
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [N_ERR-1:0] evt_vld,
   input  logic             txn_start,
   input  logic [SUB_W-1:0] sub_idx,
   output logic [N_ERR-1:0] evt_acc
);

   logic             hit_q;
   logic [SUB_W-1:0] hit_sub_q;
   logic             hit_eff;
   logic             allow;
   logic             ecc_any;

   // A new transaction forgets the previous one in the same cycle.
   assign hit_eff = hit_q && !txn_start;
   assign allow   = !hit_eff || (sub_idx == hit_sub_q);

   for (genvar i = 0; i < N_ERR; i++) begin : g_src
      if (ECC_MASK[i]) begin : g_ecc
         assign evt_acc[i] = evt_vld[i] && allow;
      end else begin : g_direct
         assign evt_acc[i] = evt_vld[i];
      end
   end

   assign ecc_any = |(evt_acc & ECC_MASK);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         hit_q     <= 1'b0;
         hit_sub_q <= '0;
      end else if (ecc_any && !hit_eff) begin
         hit_q     <= 1'b1;
         hit_sub_q <= sub_idx;
      end else if (txn_start) begin
         hit_q     <= 1'b0;
      end
   end

endmodule

// File: rtl/stk_sticky_cell.sv
module stk_sticky_cell (
   input  logic clk,
   input  logic rst_n,
   input  logic set_i,
   input  logic clr_i,
   output logic q_o
);

   always_ff @(posedge clk) begin
      if (!rst_n)     q_o <= 1'b0;
      else if (set_i) q_o <= 1'b1;
      else if (clr_i) q_o <= 1'b0;
   end

endmodule

// File: rtl/stk_multi_detect.sv
module stk_multi_detect
   import stk_fault_pkg::*;
#(
   parameter int N_ERR = 19
) (
   input  logic [N_ERR-1:0]       evt_acc,
   input  logic [N_ERR*CLS_W-1:0] evt_cls,
   input  logic [N_ERR-1:0]       err_q,
   output logic                   me_set
);

   logic [N_ERR-1:0] hard;

   for (genvar i = 0; i < N_ERR; i++) begin : g_cls
      assign hard[i] = cls_counts_repeat(evt_cls[i*CLS_W +: CLS_W]);
   end

   assign me_set = |(evt_acc & hard & err_q);

endmodule

// File: rtl/stk_fault_status.sv
module stk_fault_status
   import stk_fault_pkg::*;
#(
   parameter int REG_W    = 64,
   parameter int N_ERR    = 19,
   parameter int ERR_LO   = 33,
   parameter int PRIV_BIT = 52,
   parameter int ME_BIT   = 53,
   parameter int MSYN_LO  = 16,
   parameter int MSYN_W   = 4,
   parameter int ESYN_LO  = 0,
   parameter int ESYN_W   = 9,
   parameter int TXN_BYTES = 64,
   parameter int SUB_BYTES = 16,
   parameter int SUB_W    = 2,
   parameter logic [N_ERR-1:0] ECC_MASK  = 19'h00003,
   parameter logic [N_ERR-1:0] PIN_MASK  = 19'h60000,
   parameter logic [N_ERR-1:0] TRAP_MASK = 19'h7FFFF
) (
   input  logic                   clk,
   input  logic                   rst_n,
   input  logic [N_ERR-1:0]       evt_vld,
   input  logic [N_ERR*CLS_W-1:0] evt_cls,
   input  logic                   priv_in,
   input  logic                   txn_start,
   input  logic [SUB_W-1:0]       sub_idx,
   input  logic                   irq_en,
   input  logic                   wr_en,
   input  logic [REG_W-1:0]       wr_data,
   input  logic [MSYN_W-1:0]      msyn_in,
   input  logic [ESYN_W-1:0]      esyn_in,
   output logic [REG_W-1:0]       status_o,
   output logic                   trap_req_o,
   output logic                   err_pin_o
);

   localparam int N_SUB  = TXN_BYTES / SUB_BYTES;
   localparam int ERR_HI = ERR_LO + N_ERR - 1;

   // Elaboration checks on the parameter set.
   if (ERR_HI >= PRIV_BIT || PRIV_BIT >= ME_BIT || ME_BIT >= REG_W) begin : g_bad_layout
      $error("stk_fault_status: fault field, PRIV and ME bits overlap or exceed REG_W");
   end
   if ((1 << SUB_W) < N_SUB || N_SUB < 1) begin : g_bad_sub
      $error("stk_fault_status: SUB_W too narrow for TXN_BYTES/SUB_BYTES");
   end
   if (MSYN_LO + MSYN_W > ERR_LO || ESYN_LO + ESYN_W > MSYN_LO) begin : g_bad_syn
      $error("stk_fault_status: syndrome fields overlap");
   end

   logic [N_ERR-1:0] evt_acc;
   logic [N_ERR-1:0] err_q;
   logic [N_ERR-1:0] err_clr;
   logic             me_set;
   logic             me_q;
   logic             priv_q;
   logic             unused_ok;

   assign err_clr   = wr_en ? wr_data[ERR_LO +: N_ERR] : '0;
   assign unused_ok = ^wr_data;

   stk_ecc_gate #(
      .N_ERR    (N_ERR),
      .SUB_W    (SUB_W),
      .ECC_MASK (ECC_MASK)
   ) u_gate (
      .clk       (clk),
      .rst_n     (rst_n),
      .evt_vld   (evt_vld),
      .txn_start (txn_start),
      .sub_idx   (sub_idx),
      .evt_acc   (evt_acc)
   );

   for (genvar i = 0; i < N_ERR; i++) begin : g_bit
      stk_sticky_cell u_cell (
         .clk   (clk),
         .rst_n (rst_n),
         .set_i (evt_acc[i]),
         .clr_i (err_clr[i]),
         .q_o   (err_q[i])
      );
   end

   stk_multi_detect #(.N_ERR(N_ERR)) u_multi (
      .evt_acc (evt_acc),
      .evt_cls (evt_cls),
      .err_q   (err_q),
      .me_set  (me_set)
   );

   stk_sticky_cell u_me (
      .clk   (clk),
      .rst_n (rst_n),
      .set_i (me_set),
      .clr_i (wr_en && wr_data[ME_BIT]),
      .q_o   (me_q)
   );

   always_ff @(posedge clk) begin
      if (!rst_n)                          priv_q <= 1'b0;
      else if (|evt_acc)                   priv_q <= priv_in;
      else if (wr_en && wr_data[PRIV_BIT]) priv_q <= 1'b0;
   end

   always_comb begin
      status_o                      = '0;
      status_o[ERR_LO +: N_ERR]     = err_q;
      status_o[PRIV_BIT]            = priv_q;
      status_o[ME_BIT]              = me_q;
      status_o[MSYN_LO +: MSYN_W]   = msyn_in;
      status_o[ESYN_LO +: ESYN_W]   = esyn_in;
   end

   assign trap_req_o = irq_en && (|(err_q & TRAP_MASK));
   assign err_pin_o  = |(err_q & PIN_MASK);

endmodule

// File: rtl/stk_fault_status_chk.sv
module stk_fault_status_chk
   import stk_fault_pkg::*;
#(
   parameter int REG_W    = 64,
   parameter int N_ERR    = 19,
   parameter int ERR_LO   = 33,
   parameter int PRIV_BIT = 52,
   parameter int ME_BIT   = 53,
   parameter int MSYN_LO  = 16,
   parameter int MSYN_W   = 4,
   parameter int ESYN_LO  = 0,
   parameter int ESYN_W   = 9,
   parameter logic [N_ERR-1:0] ECC_MASK = 19'h00003,
   parameter logic [N_ERR-1:0] PIN_MASK = 19'h60000
) (
   input logic                   clk,
   input logic                   rst_n,
   input logic [N_ERR-1:0]       evt_vld,
   input logic [N_ERR*CLS_W-1:0] evt_cls,
   input logic                   irq_en,
   input logic                   wr_en,
   input logic [REG_W-1:0]       wr_data,
   input logic [REG_W-1:0]       status_o,
   input logic                   trap_req_o,
   input logic                   err_pin_o
);

   logic [N_ERR-1:0] err;
   logic [N_ERR-1:0] clrm;
   logic [N_ERR-1:0] direct_evt;
   logic             hard_any;
   logic [REG_W-1:0] used;
   logic             unused_chk;

   assign err        = status_o[ERR_LO +: N_ERR];
   assign clrm       = wr_en ? wr_data[ERR_LO +: N_ERR] : '0;
   assign direct_evt = evt_vld & ~ECC_MASK;
   assign unused_chk = ^wr_data;

   always_comb begin
      hard_any = 1'b0;
      for (int i = 0; i < N_ERR; i++)
         if (evt_vld[i] && cls_counts_repeat(evt_cls[i*CLS_W +: CLS_W])) hard_any = 1'b1;
      used = '0;
      used[ERR_LO +: N_ERR]   = '1;
      used[PRIV_BIT]          = 1'b1;
      used[ME_BIT]            = 1'b1;
      used[MSYN_LO +: MSYN_W] = '1;
      used[ESYN_LO +: ESYN_W] = '1;
   end

   // R2: a set fault bit only falls through a write-one
   p_sticky_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
      1'b1 |=> (($past(err) & ~$past(clrm) & ~err) == '0));

   // R4: a direct pulse lands even against a same-cycle clear
   p_set_wins_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (|direct_evt) |=> ((err & $past(direct_evt)) == $past(direct_evt)));

   // R6: no class-1/2 pulse, no new multiple-fault flag
   p_me_needs_hard_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (!status_o[ME_BIT] && !hard_any) |=> !status_o[ME_BIT]);

   // R9: trap request silent with interrupts disabled
   p_trap_gated_r9: assert property (@(posedge clk) disable iff (!rst_n)
      !irq_en |-> !trap_req_o);

   // R10: error pin only from protocol or internal faults
   p_pin_source_r10: assert property (@(posedge clk) disable iff (!rst_n)
      err_pin_o |-> (|(err & PIN_MASK)));

   // R11: reserved bits read zero
   p_reserved_zero_r11: assert property (@(posedge clk) disable iff (!rst_n)
      (status_o & ~used) == '0);

endmodule

bind stk_fault_status stk_fault_status_chk #(
   .REG_W    (REG_W),
   .N_ERR    (N_ERR),
   .ERR_LO   (ERR_LO),
   .PRIV_BIT (PRIV_BIT),
   .ME_BIT   (ME_BIT),
   .MSYN_LO  (MSYN_LO),
   .MSYN_W   (MSYN_W),
   .ESYN_LO  (ESYN_LO),
   .ESYN_W   (ESYN_W),
   .ECC_MASK (ECC_MASK),
   .PIN_MASK (PIN_MASK)
) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .evt_vld    (evt_vld),
   .evt_cls    (evt_cls),
   .irq_en     (irq_en),
   .wr_en      (wr_en),
   .wr_data    (wr_data),
   .status_o   (status_o),
   .trap_req_o (trap_req_o),
   .err_pin_o  (err_pin_o)
);

// File: tb/stk_fault_status_tb.sv
`timescale 1ns/1ps
module stk_fault_status_tb;

   localparam int NE = 19;
   localparam logic [NE-1:0] ECC = 19'h00003;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic [NE-1:0] evt_vld = '0;
   logic [2*NE-1:0] evt_cls = '0;
   logic          priv_in = 1'b0;
   logic          txn_start = 1'b0;
   logic [1:0]    sub_idx = '0;
   logic          irq_en = 1'b0;
   logic          wr_en = 1'b0;
   logic [63:0]   wr_data = '0;
   logic [3:0]    msyn_in = '0;
   logic [8:0]    esyn_in = '0;
   logic [63:0]   status_o;
   logic          trap_req_o;
   logic          err_pin_o;

   int total = 0;
   int bad = 0;

   // bench model
   logic [NE-1:0] m_err = '0;
   logic m_me = 0, m_priv = 0, m_hit = 0;
   logic [1:0] m_sub = '0;

   logic [63:0] q_reg[$];
   logic [1:0]  q_tp[$];
   string       q_tag[$];

   always #2.5 clk = ~clk;

   stk_fault_status u_dut (
      .clk(clk), .rst_n(rst_n), .evt_vld(evt_vld), .evt_cls(evt_cls),
      .priv_in(priv_in), .txn_start(txn_start), .sub_idx(sub_idx),
      .irq_en(irq_en), .wr_en(wr_en), .wr_data(wr_data),
      .msyn_in(msyn_in), .esyn_in(esyn_in), .status_o(status_o),
      .trap_req_o(trap_req_o), .err_pin_o(err_pin_o)
   );

   function automatic logic [2*NE-1:0] cls_all(input logic [1:0] c);
      return {NE{c}};
   endfunction

   function automatic logic [63:0] model_reg();
      logic [63:0] r = '0;
      r[51:33] = m_err;
      r[52]    = m_priv;
      r[53]    = m_me;
      r[19:16] = msyn_in;
      r[8:0]   = esyn_in;
      return r;
   endfunction

   task automatic check(input string tag, input logic [63:0] ar, input logic [63:0] er,
                        input logic [1:0] atp, input logic [1:0] etp);
      total++;
      if (ar !== er || atp !== etp) begin
         bad++;
         $display("FAIL %s: status=%h trap/pin=%b expected status=%h trap/pin=%b",
                  tag, ar, atp, er, etp);
      end
   endtask

   // driver: one cycle of stimulus, expected result pushed to the scoreboard
   task automatic step(input string tag, input logic [NE-1:0] ev, input logic [1:0] c,
                       input logic txs, input logic [1:0] sub, input logic pv,
                       input logic ien, input logic we, input logic [63:0] wd);
      logic hit_eff, allow, meset;
      logic [NE-1:0] acc, clr;
      @(negedge clk);
      evt_vld = ev; evt_cls = cls_all(c); txn_start = txs; sub_idx = sub;
      priv_in = pv; irq_en = ien; wr_en = we; wr_data = wd;
      hit_eff = m_hit && !txs;
      allow   = !hit_eff || (sub == m_sub);
      acc     = ev & ~(ECC & {NE{!allow}});
      meset   = (|(acc & m_err)) && (c == 2'd1 || c == 2'd2);
      clr     = we ? wd[51:33] : '0;
      m_err   = (m_err & ~clr) | acc;
      if (we && wd[53]) m_me = 1'b0;
      if (meset) m_me = 1'b1;
      if (|acc) m_priv = pv;
      else if (we && wd[52]) m_priv = 1'b0;
      if ((|(acc & ECC)) && !hit_eff) begin m_hit = 1'b1; m_sub = sub; end
      else if (txs) m_hit = 1'b0;
      q_reg.push_back(model_reg());
      q_tp.push_back({ien && (|m_err), m_err[18] | m_err[17]});
      q_tag.push_back(tag);
   endtask

   task automatic idle(input string tag, input logic ien);
      step(tag, '0, 2'd0, 1'b0, 2'd0, 1'b0, ien, 1'b0, '0);
   endtask

   task automatic clear_all(input string tag, input logic ien);
      step(tag, '0, 2'd0, 1'b0, 2'd0, 1'b0, ien, 1'b1, {64{1'b1}});
   endtask

   // monitor: compare each result one edge after its stimulus
   initial begin
      forever begin
         @(posedge clk);
         #1;
         if (q_reg.size() > 0)
            check(q_tag.pop_front(), status_o, q_reg.pop_front(),
                  {trap_req_o, err_pin_o}, q_tp.pop_front());
      end
   end

   initial begin
      #(200000 * 5);
      bad++;
      $display("FAIL watchdog: run did not complete, got timeout expected finish");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      repeat (3) @(posedge clk);
      @(negedge clk); rst_n = 1'b1;
      @(posedge clk); #1;
      check("R1 reset", status_o, 64'h0, {trap_req_o, err_pin_o}, 2'b00);

      // R2/R8: direct fault with privilege captured, then sticky
      step("R2 R8 set src5 priv", 19'h00020, 2'd2, 0, 0, 1'b1, 0, 0, '0);
      idle("R2 sticky idle", 0);
      idle("R2 sticky idle2", 0);
      // R3: write zeros change nothing
      step("R3 write zeros", '0, 2'd0, 0, 0, 0, 0, 1'b1, 64'h0);
      // R5: uncorrectable repeat sets ME
      step("R5 repeat unc", 19'h00020, 2'd2, 0, 0, 1'b0, 0, 0, '0);
      // R3: write-one clears selected bits only
      step("R3 w1c me+bit38", '0, 2'd0, 0, 0, 0, 0, 1'b1, (64'h1 << 53) | (64'h1 << 38));
      // R6: hw-corrected repeat leaves ME clear
      step("R6 hwc first", 19'h00080, 2'd0, 0, 0, 0, 0, 0, '0);
      step("R6 hwc repeat", 19'h00080, 2'd0, 0, 0, 0, 0, 0, '0);
      step("R6 other src swc", 19'h00100, 2'd1, 0, 0, 0, 0, 0, '0);
      step("R5 swc repeat", 19'h00100, 2'd1, 0, 0, 0, 0, 0, '0);
      // R4: set beats clear on the same bit
      step("R4 set vs clear", 19'h00080, 2'd0, 0, 0, 1'b1, 0, 1'b1, (64'h1 << 40) | (64'h1 << 53));
      // R8: privilege clears by write-one when no fault
      step("R8 priv w1c", '0, 2'd0, 0, 0, 0, 0, 1'b1, 64'h1 << 52);
      // R9: trap request follows enable and fault bits
      idle("R9 trap on", 1'b1);
      step("R9 partial clear", '0, 2'd0, 0, 0, 0, 1'b1, 1'b1, 64'h1 << 40);
      clear_all("R9 trap off", 1'b1);
      step("R9 new fault trap", 19'h00004, 2'd2, 0, 0, 0, 1'b1, 0, '0);
      clear_all("R9 clear", 1'b0);
      // R10: error pin
      step("R10 protocol", 19'h40000, 2'd2, 0, 0, 0, 0, 0, '0);
      clear_all("R10 clear", 0);
      step("R10 internal", 19'h20000, 2'd2, 0, 0, 0, 0, 0, '0);
      step("R10 unrelated", 19'h00010, 2'd0, 0, 0, 0, 0, 1'b1, 64'h1 << 50);
      clear_all("R10 clear2", 0);
      // R7: subunit filtering within a transaction
      step("R7 txn start", '0, 2'd0, 1'b1, 2'd0, 0, 0, 0, '0);
      step("R7 first ecc sub1", 19'h00002, 2'd2, 0, 2'd1, 0, 0, 0, '0);
      step("R7 same sub other", 19'h00001, 2'd0, 0, 2'd1, 0, 0, 0, '0);
      step("R7 later sub drop", 19'h00002, 2'd2, 0, 2'd2, 1'b1, 0, 0, '0);
      step("R7 drop after clear", 19'h00002, 2'd2, 0, 2'd3, 0, 0, 1'b1, 64'h1 << 34);
      step("R7 new txn accepts", 19'h00002, 2'd2, 1'b1, 2'd0, 0, 0, 0, '0);
      step("R7 repeat in same sub", 19'h00002, 2'd2, 0, 2'd0, 0, 0, 0, '0);
      clear_all("R7 clear", 0);
      // R3/R11: syndromes read-only, reserved bits stay zero
      @(negedge clk); msyn_in = 4'hA; esyn_in = 9'h155;
      clear_all("R3 R11 syndrome ro", 0);
      step("R11 all events", {NE{1'b1}}, 2'd0, 1'b1, 2'd0, 1'b1, 1'b1, 1'b1, {64{1'b1}});
      idle("R11 hold", 1'b1);
      repeat (3) @(posedge clk);
      #2;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

endmodule